// File: doc/BRIEF.md
# Digital Black Level Clamp Loop

This block keeps the black reference of a digitised image-sensor pixel stream at a fixed code. An external clamp strobe marks the optically black pixels. While the strobe is high and the loop is enabled, the block sums the difference between the black target and each 13-bit pixel. It clips that sum to a signed range and scales it by a selectable loop gain. The result is added to a saturating accumulator. The upper accumulator bits form a correction word that feeds an offset converter ahead of the digitiser, which closes the loop outside this block.

Each update uses at most `n` pixels, where `n` is a 6-bit setting. A short strobe, such as the one in a line's horizontal blanking, gives one update per strobe. A long strobe, such as one that spans the dark lines at the top of a frame, gives one update per window of `n`+10 clamped cycles. Software can overwrite the top nine accumulator bits through a write port and can read them back at any time. A disable input freezes the accumulator.

Top module: `black_clamp_loop`

## Requirements
- R1: After reset the accumulator sits at mid-scale, so `corr_o` reads 512 and `acc_rdata_o` reads 256.
- R2: Each clamped pixel contributes the error (64 − pixel), so a stream of pixels at code 64 leaves the accumulator unchanged.
- R3: Pixels presented while `clamp_i` is low contribute nothing and trigger no update.
- R4: The pixel count `n` per update comes from `npix_i`. A value of 0 behaves as 1.
- R5: A strobe shorter than `n`+10 cycles produces exactly one update. If it lasts fewer than `n` cycles, that update uses only the pixels it covered and lands on the edge after the strobe falls.
- R6: A strobe of length L produces one update per started window of `n`+10 clamped cycles. Each update uses the first min(`n`, window length) pixels of its window.
- R7: Let the clipped sum be S. An update adds S × 2^`gain_sel_i` (values 0..3 give gains 1, 2, 4, 8) to an 18-bit accumulator. The accumulator's top 10 bits drive `corr_o`, so the loop gain is gain/256 correction steps per code of error.
- R8: Before scaling, the summed error is clipped to the range −8192..8191.
- R9: The accumulator saturates at 0 and at 262143 instead of wrapping.
- R10: `acc_rdata_o` shows accumulator bits 17:9. A write with `acc_wr_i` loads those bits from `acc_wdata_i`, clears bits 8:0, discards any pending sum, and takes priority over an update.
- R11: While `loop_en_i` is low the block makes no update and the accumulator holds its value.
- R12: `update_o` goes high for exactly one cycle, and that cycle is the first one in which the new accumulator value is visible on `corr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one pixel per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_i | input | 13 | Digitised pixel value |
| clamp_i | input | 1 | High while the current pixel is optically black |
| loop_en_i | input | 1 | Loop enable; low freezes the accumulator |
| npix_i | input | 6 | Pixels summed per update (0 acts as 1) |
| gain_sel_i | input | 2 | Loop gain select: gain is 2^value |
| acc_wr_i | input | 1 | Write strobe for the accumulator's upper bits |
| acc_wdata_i | input | 9 | Value for accumulator bits 17:9 |
| acc_rdata_o | output | 9 | Accumulator bits 17:9 |
| corr_o | output | 10 | Correction word for the offset converter |
| update_o | output | 1 | One-cycle pulse marking a new accumulator value |

## Verification
The bench builds the block with its defaults: a 13-bit pixel, a 6-bit count, a 14-bit clip and an 18-bit accumulator with a 10-bit correction word. At these sizes a single 63-pixel strobe at full-scale code is enough to reach the negative clip. A write near either rail followed by one maximum-gain update is enough to reach saturation, and all four gain codes and the count-of-zero case fit in a short run. The scoreboard predicts the full sequence of updates for each strobe length. It therefore checks both when updates happen, for short, partial and multi-window strobes, and what values they produce.

// File: rtl/blc_pkg.sv
`timescale 1ns/1ps
// Shared types for the black level clamp loop.
package blc_pkg;
    // Loop gain selection codes; the gain is 2^code.
    typedef enum logic [1:0] {
        GAIN_X1 = 2'd0,
        GAIN_X2 = 2'd1,
        GAIN_X4 = 2'd2,
        GAIN_X8 = 2'd3
    } gain_e;
endpackage

// File: rtl/blc_cadence.sv
`timescale 1ns/1ps
// Update cadence control.
// Counts clamped cycles in windows of n+10. The first n pixels of each window
// are marked for summing. An update is requested once n pixels are held or
// once the strobe falls with a partial sum pending.
// Assumes npix_i stays constant while clamp_i is high. A write or a disable
// restarts the window and drops any pending sum.
module blc_cadence #(
    parameter int NPIX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clamp_i,
    input  logic              en_i,
    input  logic              wr_i,
    input  logic [NPIX_W-1:0] npix_i,
    output logic              take_o,
    output logic              apply_o
);
    localparam int WIN_W = NPIX_W + 2;

    logic [NPIX_W-1:0] n_eff;
    logic [WIN_W-1:0]  win_last;
    logic [WIN_W-1:0]  wc;
    logic [NPIX_W-1:0] taken;
    logic              have;
    logic              live;

    // Effective count and last window index.
    always_comb begin
        n_eff    = (npix_i == '0) ? NPIX_W'(1) : npix_i;
        win_last = WIN_W'(n_eff) + WIN_W'(9);
        live     = en_i && !wr_i;
        take_o   = live && clamp_i && (wc < WIN_W'(n_eff));
        apply_o  = live && have && (!clamp_i || (taken == n_eff));
    end

    // Window position, pixels held and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !live) begin
            wc    <= '0;
            taken <= '0;
            have  <= 1'b0;
        end else begin
            if (apply_o) begin
                taken <= '0;
                have  <= 1'b0;
            end else if (take_o) begin
                taken <= taken + NPIX_W'(1);
                have  <= 1'b1;
            end
            if (!clamp_i || (wc == win_last)) begin
                wc <= '0;
            end else begin
                wc <= wc + WIN_W'(1);
            end
        end
    end
endmodule

// File: rtl/blc_err_sum.sv
`timescale 1ns/1ps
// Error summation and clipping.
// Adds (TARGET - pixel) for each marked pixel into a sum wide enough for
// 2^NPIX_W pixels, and presents that sum clipped to a signed CLIP_W range.
// Assumes CLIP_W is no wider than the sum.
module blc_err_sum #(
    parameter int PIX_W  = 13,
    parameter int NPIX_W = 6,
    parameter int CLIP_W = 14,
    parameter int TARGET = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     take_i,
    input  logic [PIX_W-1:0]         pix_i,
    output logic signed [CLIP_W-1:0] clip_o
);
    localparam int SUM_W = PIX_W + NPIX_W + 1;
    localparam logic signed [SUM_W-1:0] HI = SUM_W'((1 << (CLIP_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] LO = ~HI;
    localparam logic [PIX_W:0] TGT = (PIX_W + 1)'(TARGET);

    logic signed [PIX_W:0]   err;
    logic signed [SUM_W-1:0] err_x;
    logic signed [SUM_W-1:0] sum;

    // Per-pixel error, sign-extended to the sum width.
    always_comb begin
        err   = $signed(TGT) - $signed({1'b0, pix_i});
        err_x = {{(SUM_W - PIX_W - 1){err[PIX_W]}}, err};
    end

    // Running error sum.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            sum <= '0;
        end else if (take_i) begin
            sum <= sum + err_x;
        end
    end

    // Clip to the signed output range.
    always_comb begin
        if (sum > HI) begin
            clip_o = HI[CLIP_W-1:0];
        end else if (sum < LO) begin
            clip_o = LO[CLIP_W-1:0];
        end else begin
            clip_o = sum[CLIP_W-1:0];
        end
    end
endmodule

// File: rtl/blc_accum.sv
`timescale 1ns/1ps
// Saturating loop accumulator.
// Scales the clipped error by 2^gain and adds it with saturation at both
// rails. Writes load the top RD_W bits and clear the rest. Resets to
// mid-scale. Assumes ACC_W + 2 > CLIP_W + 3.
module blc_accum #(
    parameter int CLIP_W = 14,
    parameter int DAC_W  = 10,
    parameter int FRAC_W = 8,
    parameter int RD_W   = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     apply_i,
    input  logic [1:0]               gain_sel_i,
    input  logic signed [CLIP_W-1:0] clip_i,
    input  logic                     wr_i,
    input  logic [RD_W-1:0]          wdata_i,
    output logic [DAC_W-1:0]         corr_o,
    output logic [RD_W-1:0]          rd_o,
    output logic                     upd_o
);
    import blc_pkg::*;

    localparam int ACC_W = DAC_W + FRAC_W;
    localparam int DW    = CLIP_W + 3;
    localparam int NW    = ACC_W + 2;
    localparam logic [ACC_W-1:0] MID = {1'b1, {(ACC_W - 1){1'b0}}};

    logic [ACC_W-1:0]     acc;
    logic signed [DW-1:0] ext;
    logic signed [DW-1:0] delta;
    logic signed [NW-1:0] nxt;
    logic [ACC_W-1:0]     sat;

    // Scale the clipped error by the selected gain.
    always_comb begin
        ext = {{3{clip_i[CLIP_W-1]}}, clip_i};
        case (gain_e'(gain_sel_i))
            GAIN_X1: delta = ext;
            GAIN_X2: delta = ext <<< 1;
            GAIN_X4: delta = ext <<< 2;
            default: delta = ext <<< 3;
        endcase
    end

    // Add and saturate at both rails.
    always_comb begin
        nxt = $signed({2'b00, acc}) + {{(NW - DW){delta[DW-1]}}, delta};
        if (nxt[NW-1]) begin
            sat = '0;
        end else if (nxt[NW-2:ACC_W] != '0) begin
            sat = '1;
        end else begin
            sat = nxt[ACC_W-1:0];
        end
    end

    // Accumulator register with write priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= MID;
            upd_o <= 1'b0;
        end else begin
            upd_o <= apply_i && !wr_i;
            if (wr_i) begin
                acc <= {wdata_i, {(ACC_W - RD_W){1'b0}}};
            end else if (apply_i) begin
                acc <= sat;
            end
        end
    end

    // Output slices.
    always_comb begin
        corr_o = acc[ACC_W-1 -: DAC_W];
        rd_o   = acc[ACC_W-1 -: RD_W];
    end
endmodule

// File: rtl/black_clamp_loop.sv
`timescale 1ns/1ps
// Digital black level clamp loop, top level.
// Sums the target error over clamped pixels and applies a clipped, scaled
// step to a saturating accumulator. The accumulator's top bits form the
// offset correction word. One pixel is presented per clock cycle.
module black_clamp_loop #(
    parameter int PIX_W  = 13,
    parameter int NPIX_W = 6,
    parameter int CLIP_W = 14,
    parameter int DAC_W  = 10,
    parameter int FRAC_W = 8,
    parameter int RD_W   = 9,
    parameter int TARGET = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  pix_i,
    input  logic              clamp_i,
    input  logic              loop_en_i,
    input  logic [NPIX_W-1:0] npix_i,
    input  logic [1:0]        gain_sel_i,
    input  logic              acc_wr_i,
    input  logic [RD_W-1:0]   acc_wdata_i,
    output logic [RD_W-1:0]   acc_rdata_o,
    output logic [DAC_W-1:0]  corr_o,
    output logic              update_o
);
    logic                     take;
    logic                     apply;
    logic                     sum_clr;
    logic signed [CLIP_W-1:0] clip;

    // The sum clears on each update, on a write and while disabled.
    always_comb sum_clr = apply || acc_wr_i || !loop_en_i;

    blc_cadence #(.NPIX_W(NPIX_W)) u_cad (
        .clk     (clk),
        .rst_n   (rst_n),
        .clamp_i (clamp_i),
        .en_i    (loop_en_i),
        .wr_i    (acc_wr_i),
        .npix_i  (npix_i),
        .take_o  (take),
        .apply_o (apply)
    );

    blc_err_sum #(
        .PIX_W(PIX_W), .NPIX_W(NPIX_W), .CLIP_W(CLIP_W), .TARGET(TARGET)
    ) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (sum_clr),
        .take_i  (take),
        .pix_i   (pix_i),
        .clip_o  (clip)
    );

    blc_accum #(
        .CLIP_W(CLIP_W), .DAC_W(DAC_W), .FRAC_W(FRAC_W), .RD_W(RD_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .apply_i    (apply),
        .gain_sel_i (gain_sel_i),
        .clip_i     (clip),
        .wr_i       (acc_wr_i),
        .wdata_i    (acc_wdata_i),
        .corr_o     (corr_o),
        .rd_o       (acc_rdata_o),
        .upd_o      (update_o)
    );
endmodule

// File: rtl/blc_checker.sv
`timescale 1ns/1ps
// Port-level properties of the clamp loop, bound to the top module.
module blc_checker #(
    parameter int DAC_W = 10,
    parameter int RD_W  = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             loop_en_i,
    input logic             acc_wr_i,
    input logic [RD_W-1:0]  acc_wdata_i,
    input logic [RD_W-1:0]  acc_rdata_o,
    input logic [DAC_W-1:0] corr_o,
    input logic             update_o
);
    localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W - 1){1'b0}}};

    // R1
    reset_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (corr_o == MID));

    // R10
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr_i |=> (acc_rdata_o == $past(acc_wdata_i)));

    // R11
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en_i |=> !update_o);

    // R12
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);

    // R12
    change_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(corr_o) |-> (update_o || $past(acc_wr_i)));
endmodule

bind black_clamp_loop blc_checker #(.DAC_W(DAC_W), .RD_W(RD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .loop_en_i   (loop_en_i),
    .acc_wr_i    (acc_wr_i),
    .acc_wdata_i (acc_wdata_i),
    .acc_rdata_o (acc_rdata_o),
    .corr_o      (corr_o),
    .update_o    (update_o)
);

// File: tb/black_clamp_loop_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts accumulator values per update and
// queues them; the monitor compares them when update_o pulses.
module black_clamp_loop_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] pix_i = '0;
    logic        clamp_i = 1'b0;
    logic        loop_en_i = 1'b1;
    logic [5:0]  npix_i = 6'd8;
    logic [1:0]  gain_sel_i = 2'd0;
    logic        acc_wr_i = 1'b0;
    logic [8:0]  acc_wdata_i = '0;
    logic [8:0]  acc_rdata_o;
    logic [9:0]  corr_o;
    logic        update_o;

    int checks = 0;
    int failures = 0;
    int acc_m = 131072;
    int expq[$];
    bit done = 0;

    always #5 clk = ~clk;

    black_clamp_loop u_black_clamp_loop (
        .clk(clk), .rst_n(rst_n), .pix_i(pix_i), .clamp_i(clamp_i),
        .loop_en_i(loop_en_i), .npix_i(npix_i), .gain_sel_i(gain_sel_i),
        .acc_wr_i(acc_wr_i), .acc_wdata_i(acc_wdata_i),
        .acc_rdata_o(acc_rdata_o), .corr_o(corr_o), .update_o(update_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compare each update against the next predicted value (R12).
    always @(negedge clk) begin
        if (rst_n && update_o) begin
            if (expq.size() == 0) begin
                check(0, "R12 unexpected update", 1, 0);
            end else begin
                int e;
                e = expq.pop_front();
                check(corr_o == 10'(e >> 8), "R12 corr at update", corr_o, e >> 8);
                check(acc_rdata_o == 9'(e >> 9), "R10 readback at update", acc_rdata_o, e >> 9);
            end
        end
    end

    // Driver: predict the updates of one strobe, then drive it (R5 R6).
    task automatic pulse(input int len, input int p, input int n, input int g);
        int neff;
        int rem;
        @(negedge clk);
        npix_i = 6'(n);
        gain_sel_i = 2'(g);
        pix_i = 13'(p);
        repeat (2) @(negedge clk);
        neff = (n == 0) ? 1 : n;
        rem = len;
        while (loop_en_i && rem > 0) begin
            int seg;
            int k;
            int s;
            seg = (rem < neff + 10) ? rem : neff + 10;
            k = (seg < neff) ? seg : neff;
            s = k * (64 - p);
            if (s > 8191) s = 8191;
            if (s < -8192) s = -8192;
            acc_m = acc_m + s * (1 << g);
            if (acc_m < 0) acc_m = 0;
            if (acc_m > 262143) acc_m = 262143;
            expq.push_back(acc_m);
            rem = rem - seg;
        end
        clamp_i = 1'b1;
        repeat (len) @(negedge clk);
        clamp_i = 1'b0;
        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R5/R6 update count", expq.size(), 0);
        expq.delete();
    endtask

    task automatic write_acc(input int v);
        @(negedge clk);
        acc_wr_i = 1'b1;
        acc_wdata_i = 9'(v);
        @(negedge clk);
        acc_wr_i = 1'b0;
        acc_m = v << 9;
        check(acc_rdata_o == 9'(v), "R10 write readback", acc_rdata_o, v);
        check(corr_o == 10'(acc_m >> 8), "R10 low bits cleared", corr_o, acc_m >> 8);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(corr_o == 10'd512, "R1 reset corr", corr_o, 512);
        check(acc_rdata_o == 9'd256, "R1 reset readback", acc_rdata_o, 256);
        check(update_o == 1'b0, "R1 reset update", update_o, 0);

        // R2: pixels at target leave the accumulator unchanged.
        pulse(20, 64, 16, 0);
        check(corr_o == 10'd512, "R2 target no change", corr_o, 512);
        pulse(20, 164, 16, 0);
        // R5: partial strobe shorter than n.
        pulse(5, 0, 16, 0);
        // R6: long strobe, windows of n+10.
        pulse(60, 100, 8, 1);
        // R4: a count of 0 behaves as 1.
        pulse(25, 0, 0, 0);
        // R7: all four gains.
        for (int g = 0; g < 4; g++) pulse(20, 32, 10, g);
        // R8: negative clip.
        pulse(70, 8191, 63, 3);
        check(corr_o == 10'(acc_m >> 8), "R8 clipped step", corr_o, acc_m >> 8);
        // R10: write clears the low bits.
        write_acc(9'h0AB);
        check(corr_o == 10'd342, "R10 write corr", corr_o, 342);
        // R9: saturate low.
        write_acc(1);
        pulse(70, 8191, 63, 3);
        check(corr_o == 10'd0, "R9 low rail", corr_o, 0);
        // R9: saturate high.
        write_acc(9'h1FF);
        pulse(70, 0, 63, 3);
        check(corr_o == 10'd1023, "R9 high rail corr", corr_o, 1023);
        check(acc_rdata_o == 9'd511, "R9 high rail readback", acc_rdata_o, 511);
        // R11: disabled loop holds its value.
        write_acc(9'h100);
        loop_en_i = 1'b0;
        pulse(20, 0, 8, 0);
        check(corr_o == 10'd512, "R11 frozen", corr_o, 512);
        @(negedge clk);
        loop_en_i = 1'b1;
        // R3: pixels outside the strobe are ignored.
        pix_i = 13'd0;
        repeat (30) @(negedge clk);
        check(corr_o == 10'd512, "R3 no update outside strobe", corr_o, 512);
        pulse(5, 64, 4, 0);
        check(corr_o == 10'd512, "R3 nothing carried over", corr_o, 512);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule